// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Bank

This block holds the software-visible control state for a two-channel disk DMA engine. Each channel has three registers: a command byte, a status byte and a 32-bit descriptor-table pointer. A host reaches them through a plain register port that carries an address, an access size and write data. Read data comes back combinationally in little-endian order. The engine receives one-cycle start and stop pulses for each channel. In the other direction, the engine sets the interrupt and error flags in the status byte.

The bank sits at base address `BASE` (0x20 by default). Each channel occupies 8 bytes, with channel c starting at `BASE + 8*c`. Within a channel, the command byte is at +0, the status byte at +2 and the pointer at +4..+7, least significant byte first. Every other byte, and every address below `BASE` or past the last channel, reads as zero and ignores writes.

The command byte has these fields: bit 0 is the run bit and bit 3 is the transfer direction. The remaining bits are plain storage. The status byte has these fields: bit 0 is the transfer-active flag, bit 1 is the error flag and bit 2 is the interrupt flag. Bits 3..7 are plain storage, and bits 5 and 6 reset to one. The access size code is 0 for one byte, 1 for two bytes, 2 for four bytes and 3 for invalid.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every command byte and pointer reads zero and every status byte reads 0x60.
- R2: While `io_en` is low, host writes change nothing and raise no error, and `host_rdata` is zero.
- R3: While `bm_en` is low and `io_en` is high, writes into the bank change nothing and raise no error, and reads still return register contents.
- R4: The command and status bytes accept only size code 0, and the pointer accepts only size code 2 at offset +4. Any other size aimed at one of these bytes, or any write at +5..+7, leaves the registers unchanged and pulses `size_err` in the following cycle. A read with size code 3 returns zero and also pulses `size_err`.
- R5: While the run bit (command bit 0) is set, a command write keeps the stored direction bit (command bit 3). All other bits take the written value.
- R6: A command write that takes the run bit from 0 to 1 sets status bit 0. It also pulses that channel's `dma_start` for one cycle, in the cycle after the write.
- R7: A command write that takes the run bit from 1 to 0 clears status bit 0. It also pulses that channel's `dma_stop` for one cycle, in the cycle after the write.
- R8: Status writes never change status bit 0.
- R9: Status bits 1 and 2 clear when a write carries a 1 in that position. A 0 in that position leaves the bit unchanged. Bits 3..7 take the written value.
- R10: A pointer write stores the data with bits 1:0 forced to zero.
- R11: A command write that would start or stop a channel whose `dev_present` bit is low keeps the old run bit and leaves status bit 0 unchanged. It produces no start or stop pulse and instead pulses that channel's `start_err` in the following cycle.
- R12: `eng_err_set` sets status bit 1 and `eng_int_set` sets status bit 2. A set input wins over a software clear in the same cycle.
- R13: A read of 1, 2 or 4 bytes returns the bytes at `addr`, `addr+1`, … in little-endian order, with unmapped bytes reading as zero and the unused upper bytes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Gates all host access |
| bm_en | input | 1 | Gates writes into the bank |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | ADDR_W | Byte address |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Write data, least significant byte at `host_addr` |
| host_rdata | output | 32 | Read data |
| size_err | output | 1 | Access size error pulse |
| dev_present | input | NCH | Device present on each channel |
| eng_int_set | input | NCH | Engine sets interrupt flag |
| eng_err_set | input | NCH | Engine sets error flag |
| dma_start | output | NCH | Start pulse to engine |
| dma_stop | output | NCH | Stop pulse to engine |
| start_err | output | NCH | Start/stop to absent device |

## Verification
The hardest situation to reach is a status write that meets flags already set. Both write-one-to-clear flags can only become one through the engine inputs, and the active flag can only become one through a run-bit edge on the command byte. The bench therefore first leaves each channel running. For every one of the 256 status data values, it sets both flags from the engine side and then writes that value. It also drives an engine set in the same cycle as a clearing write, to exercise the priority rule. The command sweep walks all 256 values in order, so the run bit toggles on every write and the direction lock is exercised in both states.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  localparam int CH_STRIDE = 8;
  localparam int OFS_CMD   = 0;
  localparam int OFS_STS   = 2;
  localparam int OFS_PTR   = 4;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  localparam int STS_ACT = 0;
  localparam int STS_ERR = 1;
  localparam int STS_INT = 2;

  localparam logic [7:0] STS_RST = 8'h60;
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic        wr_sts,
  input  logic        wr_ptr,
  input  logic [31:0] wdata,
  input  logic        dev_present,
  input  logic        int_set,
  input  logic        err_set,
  output logic [7:0]  cmd_q,
  output logic [7:0]  sts_q,
  output logic [31:0] ptr_q,
  output logic        start_p,
  output logic        stop_p,
  output logic        start_err
);
  logic [7:0]  cmd_d, sts_d;
  logic [31:0] ptr_d;
  logic        rise, fall, bad, start_d, stop_d;
  logic        cmd_en, sts_en, ptr_en;

  always_comb begin
    cmd_d = wdata[7:0];
    if (cmd_q[CMD_RUN]) cmd_d[CMD_DIR] = cmd_q[CMD_DIR];
    rise    = wr_cmd & ~cmd_q[CMD_RUN] &  cmd_d[CMD_RUN];
    fall    = wr_cmd &  cmd_q[CMD_RUN] & ~cmd_d[CMD_RUN];
    bad     = (rise | fall) & ~dev_present;
    if (bad) cmd_d[CMD_RUN] = cmd_q[CMD_RUN];
    start_d = rise & dev_present;
    stop_d  = fall & dev_present;

    sts_d = sts_q;
    if (wr_sts) begin
      sts_d          = wdata[7:0];
      sts_d[STS_ACT] = sts_q[STS_ACT];
      sts_d[STS_ERR] = sts_q[STS_ERR] & ~wdata[STS_ERR];
      sts_d[STS_INT] = sts_q[STS_INT] & ~wdata[STS_INT];
    end
    if (start_d) sts_d[STS_ACT] = 1'b1;
    if (stop_d)  sts_d[STS_ACT] = 1'b0;
    sts_d[STS_ERR] = sts_d[STS_ERR] | err_set;
    sts_d[STS_INT] = sts_d[STS_INT] | int_set;

    ptr_d = {wdata[31:2], 2'b00};

    cmd_en = wr_cmd;
    sts_en = wr_sts | start_d | stop_d | err_set | int_set;
    ptr_en = wr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      sts_q     <= STS_RST;
      ptr_q     <= '0;
      start_p   <= 1'b0;
      stop_p    <= 1'b0;
      start_err <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      if (sts_en) sts_q <= sts_d;
      if (ptr_en) ptr_q <= ptr_d;
      start_p   <= start_d;
      stop_p    <= stop_d;
      start_err <= bad;
    end
  end

  p_dir_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[CMD_RUN] |=> $stable(cmd_q[CMD_DIR]));
  p_start_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> sts_q[STS_ACT]);
  p_stop_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |-> !sts_q[STS_ACT]);
  p_act_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !wr_cmd) |=> sts_q[STS_ACT] == $past(sts_q[STS_ACT]));
  p_dev_needed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || stop_p) |-> $past(dev_present));
  p_int_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    int_set |=> sts_q[STS_INT]);
  p_err_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> sts_q[STS_ERR]);
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 6,
  parameter int BASE   = 32
) (
  input  logic                   en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [1:0]             size,
  input  logic [NCH-1:0][7:0]    cmd,
  input  logic [NCH-1:0][7:0]    sts,
  input  logic [NCH-1:0][31:0]   ptr,
  output logic [31:0]            rdata
);
  function automatic logic [7:0] byte_at(int a);
    int o, s;
    logic [7:0] b;
    b = '0;
    o = a - BASE;
    s = o % CH_STRIDE;
    for (int c = 0; c < NCH; c++) begin
      if (o >= c * CH_STRIDE && o < (c + 1) * CH_STRIDE) begin
        if (s == OFS_CMD)      b = cmd[c];
        else if (s == OFS_STS) b = sts[c];
        else if (s >= OFS_PTR) b = ptr[c][8*(s-OFS_PTR) +: 8];
      end
    end
    return b;
  endfunction

  always_comb begin
    int nb;
    rdata = '0;
    case (acc_size_e'(size))
      SZ_B1:   nb = 1;
      SZ_B2:   nb = 2;
      SZ_B4:   nb = 4;
      default: nb = 0;
    endcase
    if (en) begin
      for (int k = 0; k < 4; k++) begin
        if (k < nb) rdata[8*k +: 8] = byte_at(int'(addr) + k);
      end
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 6,
  parameter int BASE   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              bm_en,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              size_err,
  input  logic [NCH-1:0]    dev_present,
  input  logic [NCH-1:0]    eng_int_set,
  input  logic [NCH-1:0]    eng_err_set,
  output logic [NCH-1:0]    dma_start,
  output logic [NCH-1:0]    dma_stop,
  output logic [NCH-1:0]    start_err
);
  localparam int BANK_BYTES = NCH * CH_STRIDE;

  logic [1:0]            rst_pipe;
  logic                  rst_s_n;
  logic [NCH-1:0]        wr_cmd, wr_sts, wr_ptr;
  logic [NCH-1:0][7:0]   cmd_all, sts_all;
  logic [NCH-1:0][31:0]  ptr_all;
  logic                  size_err_d;
  acc_size_e             sz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign sz = acc_size_e'(host_size);

  always_comb begin
    int  o, s;
    logic in_bank, wr_ok, bad_wr, bad_rd;
    o       = int'(host_addr) - BASE;
    s       = o % CH_STRIDE;
    in_bank = (o >= 0) && (o < BANK_BYTES);
    wr_ok   = host_wr && io_en && bm_en && in_bank;
    for (int c = 0; c < NCH; c++) begin
      wr_cmd[c] = wr_ok && (o / CH_STRIDE == c) && (s == OFS_CMD) && (sz == SZ_B1);
      wr_sts[c] = wr_ok && (o / CH_STRIDE == c) && (s == OFS_STS) && (sz == SZ_B1);
      wr_ptr[c] = wr_ok && (o / CH_STRIDE == c) && (s == OFS_PTR) && (sz == SZ_B4);
    end
    bad_wr = wr_ok && ((((s == OFS_CMD) || (s == OFS_STS)) && (sz != SZ_B1)) ||
                       ((s >= OFS_PTR) && !((s == OFS_PTR) && (sz == SZ_B4))));
    bad_rd = host_rd && io_en && (sz == SZ_BAD);
    size_err_d = bad_wr || bad_rd;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) size_err <= 1'b0;
    else          size_err <= size_err_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    bmdma_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_s_n),
      .wr_cmd      (wr_cmd[c]),
      .wr_sts      (wr_sts[c]),
      .wr_ptr      (wr_ptr[c]),
      .wdata       (host_wdata),
      .dev_present (dev_present[c]),
      .int_set     (eng_int_set[c]),
      .err_set     (eng_err_set[c]),
      .cmd_q       (cmd_all[c]),
      .sts_q       (sts_all[c]),
      .ptr_q       (ptr_all[c]),
      .start_p     (dma_start[c]),
      .stop_p      (dma_stop[c]),
      .start_err   (start_err[c])
    );
  end

  bmdma_rdmux #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE)) u_rdmux (
    .en    (io_en & host_rd),
    .addr  (host_addr),
    .size  (host_size),
    .cmd   (cmd_all),
    .sts   (sts_all),
    .ptr   (ptr_all),
    .rdata (host_rdata)
  );

  p_io_gate_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (host_wr && !io_en) |=> ($stable(cmd_all) && $stable(ptr_all) && !size_err));
  p_bm_gate_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (host_wr && !bm_en) |=> ($stable(cmd_all) && $stable(ptr_all)));
  p_rd_off_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !io_en |-> host_rdata == 32'h0);
  p_start_stop_excl_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dma_start & dma_stop) == '0);
endmodule

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
  localparam int NCH  = 2;
  localparam int AW   = 6;
  localparam int BASE = 32;

  logic clk = 1'b0;
  logic rst_n, io_en, bm_en, host_wr, host_rd;
  logic [AW-1:0] host_addr;
  logic [1:0] host_size;
  logic [31:0] host_wdata, host_rdata;
  logic size_err;
  logic [NCH-1:0] dev_present, eng_int_set, eng_err_set, dma_start, dma_stop, start_err;

  always #5 clk = ~clk;

  bmdma_regs #(.NCH(NCH), .ADDR_W(AW), .BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_size(host_size), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .size_err(size_err), .dev_present(dev_present), .eng_int_set(eng_int_set),
    .eng_err_set(eng_err_set), .dma_start(dma_start), .dma_stop(dma_stop),
    .start_err(start_err)
  );

  int total = 0;
  int fails = 0;
  logic [7:0]  mc [NCH];
  logic [7:0]  ms [NCH];
  logic [31:0] mp [NCH];
  logic e_err;
  logic [NCH-1:0] e_start, e_stop, e_serr;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(int a);
    int o, c, s;
    o = a - BASE;
    if (o < 0 || o >= NCH * 8) return 8'h00;
    c = o / 8;
    s = o % 8;
    if (s == 0) return mc[c];
    if (s == 2) return ms[c];
    if (s >= 4) return mp[c][8*(s-4) +: 8];
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_read(int a, int sz);
    logic [31:0] r;
    int n;
    r = '0;
    if (!io_en || sz == 3) return r;
    n = 1 << sz;
    for (int k = 0; k < n; k++) r[8*k +: 8] = mbyte(a + k);
    return r;
  endfunction

  task automatic model_write(int a, int sz, logic [31:0] d);
    int o, c, s;
    logic [7:0] n, old;
    logic on, off;
    e_err = 1'b0; e_start = '0; e_stop = '0; e_serr = '0;
    if (!io_en || !bm_en) return;
    o = a - BASE;
    if (o < 0 || o >= NCH * 8) return;
    c = o / 8;
    s = o % 8;
    if (s == 0 || s == 2) begin
      if (sz != 0) begin e_err = 1'b1; return; end
      if (s == 0) begin
        old = mc[c];
        n = d[7:0];
        if (old[0]) n[3] = old[3];
        on = !old[0] && n[0];
        off = old[0] && !n[0];
        if ((on || off) && !dev_present[c]) begin
          n[0] = old[0];
          e_serr[c] = 1'b1;
        end else begin
          e_start[c] = on;
          e_stop[c] = off;
          if (on) ms[c][0] = 1'b1;
          if (off) ms[c][0] = 1'b0;
        end
        mc[c] = n;
      end else begin
        old = ms[c];
        n = d[7:0];
        n[0] = old[0];
        n[1] = old[1] & ~d[1];
        n[2] = old[2] & ~d[2];
        ms[c] = n;
      end
    end else if (s >= 4) begin
      if (s == 4 && sz == 2) mp[c] = {d[31:2], 2'b00};
      else e_err = 1'b1;
    end
  endtask

  task automatic rd(string req, int a, int sz);
    logic [31:0] exp;
    @(negedge clk);
    host_rd = 1'b1; host_addr = AW'(a); host_size = 2'(sz);
    exp = exp_read(a, sz);
    #1;
    chk(req, $sformatf("read @%0h size %0d", a, sz), host_rdata, exp);
    @(negedge clk);
    host_rd = 1'b0;
    chk(req, "read size_err", {31'b0, size_err}, {31'b0, (io_en && sz == 3)});
  endtask

  task automatic readback(string req);
    for (int c = 0; c < NCH; c++) begin
      rd(req, BASE + 8*c, 2);
      rd(req, BASE + 8*c + 4, 2);
    end
  endtask

  task automatic wr(string req, int a, int sz, logic [31:0] d,
                    logic [NCH-1:0] im, logic [NCH-1:0] em);
    @(negedge clk);
    host_wr = 1'b1; host_addr = AW'(a); host_size = 2'(sz); host_wdata = d;
    eng_int_set = im; eng_err_set = em;
    model_write(a, sz, d);
    for (int c = 0; c < NCH; c++) begin
      if (im[c]) ms[c][2] = 1'b1;
      if (em[c]) ms[c][1] = 1'b1;
    end
    @(negedge clk);
    host_wr = 1'b0; eng_int_set = '0; eng_err_set = '0;
    chk(req, "size_err", {31'b0, size_err}, {31'b0, e_err});
    chk(req, "dma_start", {30'b0, dma_start}, {30'b0, e_start});
    chk(req, "dma_stop", {30'b0, dma_stop}, {30'b0, e_stop});
    chk(req, "start_err", {30'b0, start_err}, {30'b0, e_serr});
    readback(req);
  endtask

  task automatic eng(logic [NCH-1:0] im, logic [NCH-1:0] em);
    @(negedge clk);
    eng_int_set = im; eng_err_set = em;
    for (int c = 0; c < NCH; c++) begin
      if (im[c]) ms[c][2] = 1'b1;
      if (em[c]) ms[c][1] = 1'b1;
    end
    @(negedge clk);
    eng_int_set = '0; eng_err_set = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_en = 1'b0; bm_en = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_addr = '0; host_size = '0; host_wdata = '0;
    dev_present = '1; eng_int_set = '0; eng_err_set = '0;
    for (int c = 0; c < NCH; c++) begin mc[c] = 8'h00; ms[c] = 8'h60; mp[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "dma_start after reset", {30'b0, dma_start}, 32'h0);

    // R2: everything gated off by io_en
    rd("R2", BASE, 2);
    wr("R2", BASE + 4, 2, 32'h1234_5677, '0, '0);
    wr("R2", BASE, 1, 32'h0, '0, '0);
    // R1: reset values
    io_en = 1'b1; bm_en = 1'b1;
    readback("R1");
    // R3: bank writes gated by bm_en, reads still work
    bm_en = 1'b0;
    wr("R3", BASE + 4, 2, 32'hDEAD_BEEF, '0, '0);
    wr("R3", BASE + 8, 0, 32'h0000_0001, '0, '0);
    bm_en = 1'b1;
    // R10: pointer low bits forced to zero
    for (int i = 0; i < 16; i++)
      wr("R10", BASE + 8*(i % 2) + 4, 2, 32'h1357_9BD0 ^ (i * 32'h0111_1113), '0, '0);
    // R4: size sweep over every byte offset of both channels
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 8; s++)
        for (int z = 0; z < 4; z++)
          wr("R4", BASE + 8*c + s, z, 32'hA5A5_5AF0, '0, '0);
    rd("R4", BASE, 3);
    // R5 R6 R7: full command sweep, run bit toggles every write
    for (int c = 0; c < NCH; c++)
      for (int v = 0; v < 256; v++)
        wr("R5_R6_R7", BASE + 8*c, 0, 32'(v), '0, '0);
    // R8 R9: status sweep with flags preset by the engine, channels running
    for (int c = 0; c < NCH; c++)
      for (int v = 0; v < 256; v++) begin
        eng(NCH'(1 << c), NCH'(1 << c));
        wr("R8_R9", BASE + 8*c + 2, 0, 32'(v), '0, '0);
      end
    // R12: engine set beats software clear in the same cycle
    wr("R12", BASE + 2, 0, 32'h06, 2'b01, 2'b00);
    wr("R12", BASE + 10, 0, 32'h06, 2'b00, 2'b10);
    wr("R12", BASE + 2, 0, 32'h06, 2'b00, 2'b00);
    // R11: absent device rejects start and stop
    dev_present = 2'b01;
    wr("R11", BASE + 8, 0, 32'h00, '0, '0);
    dev_present = 2'b11;
    wr("R11", BASE + 8, 0, 32'h00, '0, '0);
    dev_present = 2'b01;
    wr("R11", BASE + 8, 0, 32'h09, '0, '0);
    dev_present = 2'b11;
    wr("R8", BASE + 2, 0, 32'hFF, '0, '0);
    // R13: reads of every size across and beyond the bank
    for (int a = BASE - 3; a < BASE + 8*NCH + 2; a++)
      for (int z = 0; z < 3; z++)
        rd("R13", a, z);
    summary();
    $finish;
  end
endmodule